// File: doc/BRIEF.md
# Privileged Status Register Controller

This block holds the machine status word of a small processor core. The word carries a two-bit privilege mode, an interrupt-enable bit, two level bits (one for error-class exceptions, one for ordinary exceptions) and a 9-bit diagnostic field. The field records a soft reset, a non-maskable interrupt and a translation-conflict event, and it has one bit that is reserved and always reads as zero.

When the pipeline takes an exception, it pulses `exc_valid` together with a class code. The block then sets the matching level bit and updates the diagnostic flags for that class. A return-from-exception strobe undoes one level, with the error level unwound first. Software can load the whole word through the write port and can read it back at any time.

Two outputs are decoded from the word for the rest of the core. `eff_mode` gives the privilege the core is running at. `int_en_o` is the global qualifier that lets interrupts through. While either level bit is set, the core runs in kernel mode and interrupts are held off.

Top module: `priv_status_ctrl`

## Requirements
- R1: `rd_data[4:3]` is the mode field, coded 00 kernel, 01 supervisor, 10 user and 11 undefined. With both level bits clear, `eff_mode` equals the field, except that code 11 drives `eff_mode` = 10 (user).
- R2: Exception classes on `exc_class` are coded 0 reset, 1 soft reset, 2 NMI, 3 cache error, and 4 to 7 for any other exception. An exception with class 0 to 3 sets the error-level bit `rd_data[2]` and leaves the exception-level bit `rd_data[1]` unchanged.
- R3: An exception of class 4 to 7 sets the exception-level bit `rd_data[1]`. It leaves the error-level bit and the diagnostic flags unchanged.
- R4: With both level bits clear, `int_en_o` equals the interrupt-enable bit `rd_data[0]`.
- R5: While `rd_data[2]` or `rd_data[1]` is 1, `eff_mode` is 00 and `int_en_o` is 0, whatever the mode field and the enable bit hold.
- R6: Flags: the soft-reset flag is `rd_data[8]` and the NMI flag is `rd_data[7]`. A soft reset sets the soft-reset flag and clears the NMI flag. An NMI sets both flags. A reset class clears both flags. Classes 3 to 7 leave both flags unchanged.
- R7: The translation-conflict flag `rd_data[5]` is cleared by classes 0, 1 and 2, and is kept by all other classes.
- R8: The reserved diagnostic bit `rd_data[6]` always reads 0, even after software writes 1 to it.
- R9: If an exception and a software write arrive in the same cycle, the exception update is applied and the written data is discarded entirely.
- R10: A return strobe without an exception clears the error-level bit if it is set, and otherwise clears the exception-level bit. It takes precedence over a write in the same cycle.
- R11: After `rst_n` is released, the word reads 0x0004: error level set and all other bits 0.
- R12: A write with no exception or return in the same cycle stores `wr_data` into every bit except bit 6. The new value is visible on `rd_data` after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | An exception is taken this cycle |
| exc_class | input | 3 | Class of the exception taken |
| eret | input | 1 | Return-from-exception strobe |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 14 | Word to write |
| rd_data | output | 14 | Current status word |
| eff_mode | output | 2 | Effective privilege mode |
| int_en_o | output | 1 | Global interrupt qualifier |

## Verification
Every update of the word is registered. A strobe sampled at one rising edge therefore shows on `rd_data` right after that edge, and is not visible before it. `eff_mode` and `int_en_o` are decoded directly from the stored word, so they change in the same cycle as `rd_data`. The bench drives each strobe for exactly one edge and samples every output 2 ns after that edge, before it drives anything else. The expected words are written out as constants derived from the bit layout in the requirements.

// File: rtl/priv_status_ctrl.sv
module priv_status_ctrl #(
  parameter int DIAG_W = 9,
  localparam int REG_W = 5 + DIAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_valid,
  input  logic [2:0]       exc_class,
  input  logic             eret,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic [1:0]       eff_mode,
  output logic             int_en_o
);

  localparam int B_IE   = 0;
  localparam int B_EXL  = 1;
  localparam int B_ERL  = 2;
  localparam int B_MODE = 3;
  localparam int B_DIAG = 5;
  localparam int D_TLBC = 0;
  localparam int D_RSVD = 1;
  localparam int D_NMI  = 2;
  localparam int D_SRST = 3;

  localparam logic [2:0] CLS_RESET = 3'd0;
  localparam logic [2:0] CLS_SOFT  = 3'd1;
  localparam logic [2:0] CLS_NMI   = 3'd2;
  localparam logic [2:0] CLS_CACHE = 3'd3;

  logic              ie_q, exl_q, erl_q;
  logic [1:0]        mode_q;
  logic [DIAG_W-1:0] diag_q;

  logic              ie_n, exl_n, erl_n;
  logic [1:0]        mode_n;
  logic [DIAG_W-1:0] diag_n;

  always_comb begin
    ie_n   = ie_q;
    exl_n  = exl_q;
    erl_n  = erl_q;
    mode_n = mode_q;
    diag_n = diag_q;
    if (exc_valid) begin
      case (exc_class)
        CLS_RESET: begin
          erl_n          = 1'b1;
          diag_n[D_TLBC] = 1'b0;
          diag_n[D_SRST] = 1'b0;
          diag_n[D_NMI]  = 1'b0;
        end
        CLS_SOFT: begin
          erl_n          = 1'b1;
          diag_n[D_TLBC] = 1'b0;
          diag_n[D_SRST] = 1'b1;
          diag_n[D_NMI]  = 1'b0;
        end
        CLS_NMI: begin
          erl_n          = 1'b1;
          diag_n[D_TLBC] = 1'b0;
          diag_n[D_SRST] = 1'b1;
          diag_n[D_NMI]  = 1'b1;
        end
        CLS_CACHE: erl_n = 1'b1;
        default:   exl_n = 1'b1;
      endcase
    end else if (eret) begin
      if (erl_q) erl_n = 1'b0;
      else       exl_n = 1'b0;
    end else if (wr_en) begin
      ie_n   = wr_data[B_IE];
      exl_n  = wr_data[B_EXL];
      erl_n  = wr_data[B_ERL];
      mode_n = wr_data[B_MODE +: 2];
      diag_n = wr_data[B_DIAG +: DIAG_W];
    end
    diag_n[D_RSVD] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      exl_q  <= 1'b0;
      erl_q  <= 1'b1;
      mode_q <= 2'b00;
      diag_q <= '0;
    end else begin
      ie_q   <= ie_n;
      exl_q  <= exl_n;
      erl_q  <= erl_n;
      mode_q <= mode_n;
      diag_q <= diag_n;
    end
  end

  assign rd_data  = {diag_q, mode_q, erl_q, exl_q, ie_q};
  assign eff_mode = (erl_q || exl_q) ? 2'b00 :
                    (mode_q == 2'b11) ? 2'b10 : mode_q;
  assign int_en_o = ie_q & ~erl_q & ~exl_q;

endmodule

module priv_status_chk #(
  parameter int DIAG_W = 9,
  localparam int REG_W = 5 + DIAG_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exc_valid,
  input logic [2:0]       exc_class,
  input logic             eret,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic [1:0]       eff_mode,
  input logic             int_en_o
);

  AST_MODE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[2] && !rd_data[1]) |-> (eff_mode == ((rd_data[4:3] == 2'b11) ? 2'b10 : rd_data[4:3]))); // R1
  AST_ERL_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_class <= 3'd3) |=> rd_data[2]); // R2
  AST_EXL_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_class >= 3'd4) |=> (rd_data[1] && $stable(rd_data[2]))); // R3
  AST_IE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[2] && !rd_data[1]) |-> (int_en_o == rd_data[0])); // R4
  AST_LEVEL_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2] || rd_data[1]) |-> (eff_mode == 2'b00 && !int_en_o)); // R5
  AST_NMI_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_class == 3'd2) |=> (rd_data[8] && rd_data[7] && !rd_data[5])); // R6
  AST_SOFT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_class == 3'd1) |=> (rd_data[8] && !rd_data[7] && !rd_data[5])); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[6]) |=> !rd_data[6]); // R8
  AST_WRITE_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && wr_en && exc_class >= 3'd4 && !wr_data[1]) |=> rd_data[1]); // R9
  AST_ERET_ERL: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !exc_valid && rd_data[2]) |=> (!rd_data[2] && $stable(rd_data[1]))); // R10

endmodule

bind priv_status_ctrl priv_status_chk #(.DIAG_W(DIAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_class(exc_class),
  .eret(eret), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .eff_mode(eff_mode), .int_en_o(int_en_o)
);

// File: tb/test_priv_status_ctrl.sv
`timescale 1ns/1ps
module test_priv_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [2:0]  exc_class = 3'd0;
  logic        eret = 1'b0;
  logic        wr_en = 1'b0;
  logic [13:0] wr_data = '0;
  logic [13:0] rd_data;
  logic [1:0]  eff_mode;
  logic        int_en_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  priv_status_ctrl i_priv_status_ctrl (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_class(exc_class),
    .eret(eret), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .eff_mode(eff_mode), .int_en_o(int_en_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #2;
    exc_valid = 1'b0;
    eret = 1'b0;
    wr_en = 1'b0;
  endtask

  task automatic do_write(input logic [13:0] d);
    wr_en = 1'b1; wr_data = d; edge_step();
  endtask

  task automatic do_exc(input logic [2:0] c);
    exc_valid = 1'b1; exc_class = c; edge_step();
  endtask

  task automatic do_eret();
    eret = 1'b1; edge_step();
  endtask

  task automatic t_reset();
    chk("R11 reset word", rd_data, 14'h0004);
    chk("R5 reset mode", eff_mode, 2'b00);
    chk("R5 reset int", int_en_o, 0);
  endtask

  task automatic t_modes();
    do_write(14'h0011);
    chk("R12 write user", rd_data, 14'h0011);
    chk("R1 user", eff_mode, 2'b10);
    chk("R4 ie on", int_en_o, 1);
    do_write(14'h0008);
    chk("R1 supervisor", eff_mode, 2'b01);
    chk("R4 ie off", int_en_o, 0);
    do_write(14'h0019);
    chk("R1 undefined as user", eff_mode, 2'b10);
    do_write(14'h0001);
    chk("R1 kernel", eff_mode, 2'b00);
  endtask

  task automatic t_rsvd();
    do_write(14'h3FFF);
    chk("R8 reserved bit zero", rd_data, 14'h3FBF);
    chk("R5 levels force kernel", eff_mode, 2'b00);
    chk("R5 levels mask int", int_en_o, 0);
  endtask

  task automatic t_other_eret();
    do_write(14'h0039);
    do_exc(3'd4);
    chk("R3 other sets exl", rd_data, 14'h003B);
    chk("R5 exl kernel", eff_mode, 2'b00);
    do_eret();
    chk("R10 eret clears exl", rd_data, 14'h0039);
    chk("R4 ie after eret", int_en_o, 1);
    do_write(14'h0000);
    do_exc(3'd7);
    chk("R3 class 7 as other", rd_data, 14'h0002);
  endtask

  task automatic t_err_classes();
    do_write(14'h0039);
    do_exc(3'd2);
    chk("R6 nmi flags", rd_data, 14'h019D);
    do_write(14'h0039);
    do_exc(3'd1);
    chk("R6 soft reset flags", rd_data, 14'h011D);
    do_write(14'h0039);
    do_exc(3'd3);
    chk("R7 cache error keeps tlbc", rd_data, 14'h003D);
    do_write(14'h01B9);
    do_exc(3'd0);
    chk("R2 reset class", rd_data, 14'h001D);
    do_write(14'h01A0);
    do_exc(3'd4);
    chk("R7 other keeps flags", rd_data, 14'h01A2);
  endtask

  task automatic t_nested_eret();
    do_write(14'h0006);
    do_eret();
    chk("R10 erl first", rd_data, 14'h0002);
    do_eret();
    chk("R10 then exl", rd_data, 14'h0000);
    eret = 1'b1; wr_en = 1'b1; wr_data = 14'h0019; do_write(14'h0019);
    chk("R10 eret beats write", rd_data, 14'h0000);
  endtask

  task automatic t_collide();
    exc_valid = 1'b1; exc_class = 3'd4;
    do_write(14'h0019);
    chk("R9 exception beats write", rd_data, 14'h0002);
    exc_valid = 1'b1; exc_class = 3'd3;
    do_write(14'h0000);
    chk("R9 error class beats write", rd_data, 14'h0006);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_modes();
    t_rsvd();
    t_other_eret();
    t_err_classes();
    t_nested_eret();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule